// File: doc/BRIEF.md
# Two-Channel Bus-Master DMA Control Registers

This block holds the host-visible control state of a two-channel bus-master disk DMA engine. Each channel has a command byte, a status byte, a descriptor-table pointer and two spare bytes. Host software reaches all of them through one 16-byte window. It can read and write a byte, a 16-bit word or a 32-bit dword at any offset. The block gives each register its own write rules. It also turns edges on the command register's run bit into one-cycle start and abort pulses toward the DMA engine. A start pulse carries the channel's descriptor pointer. An abort pulse carries the index of the drive that the channel has selected.

When the engine finishes a transfer, it raises a per-channel completion input. The block then stops the channel, drops its busy flag and sets its interrupt flag. Software clears the interrupt flag by writing a one to it. The descriptor walk, the data movement and the configuration space sit outside this block.

Channel `c` occupies offsets `8c` to `8c+7`:

| Offset | Content |
|---|---|
| `+0` | Command byte |
| `+1` | Spare byte 0 |
| `+2` | Status byte |
| `+3` | Spare byte 1 |
| `+4` to `+7` | Descriptor pointer, little-endian |

Top module: `bmide_regs`

## Requirements
- R1: After reset, each status byte reads 0x60 and every other byte of the window reads 0. `dma_start` and `dma_abort` are low.
- R2: The command byte changes only on a byte write (size code 0) at its own offset. A word or dword write that starts there changes nothing and raises no pulse.
- R3: While command bit 0 (run) is set, command bit 3 (direction) keeps its value whatever is written.
- R4: A byte write that takes run from 0 to 1 sets status bit 0 (busy). One cycle after the write edge, `dma_start` is high for exactly one cycle. During that cycle `dma_ptr` holds the channel's stored pointer and `dma_drive` = 2*channel + `drv_sel[channel]`.
- R5: A byte write that takes run from 1 to 0 clears busy. It raises a one-cycle `dma_abort` with `dma_drive` = 2*channel + `drv_sel[channel]`. Start and abort are never high together.
- R6: The status byte changes only on a byte write at its own offset. Its busy bit ignores writes. Bits 7..3 take the written value.
- R7: Status bit 2 (interrupt) and bit 1 (error) clear when a 1 is written while they are set. Writing 0 keeps them. Writing 1 never sets them.
- R8: The pointer changes only on a dword write (size code 2) at channel offset +4. Its bits 1..0 are stored as 0.
- R9: A `dma_done[c]` cycle clears run and busy of channel c and sets its interrupt bit. The completion overrides a same-cycle write to that channel's command or status byte, and that command write raises no pulse.
- R10: A byte, word or dword write that starts at a spare byte stores the bytes it covers that are spare bytes. Any other bytes it covers are left unchanged.
- R11: `rdata` is combinational and little-endian. It returns 1, 2 or 4 bytes from `addr` for size codes 0, 1 and 2. Bytes past the end of the window, and size code 3, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 4 | Byte offset in the window, for reads and writes |
| size | input | 2 | Access size: 0 byte, 1 word, 2 dword, 3 invalid |
| wdata | input | 32 | Write data, little-endian |
| rdata | output | 32 | Read data for `addr` and `size` |
| drv_sel | input | 2 | Per-channel selected drive (0 or 1) |
| dma_done | input | 2 | Per-channel transfer-complete strobe |
| dma_start | output | 1 | One-cycle start request |
| dma_abort | output | 1 | One-cycle abort request |
| dma_drive | output | 2 | Drive index of the pending request |
| dma_ptr | output | 32 | Descriptor pointer carried with a start request |

## Verification
Reads are combinational, so the bench samples `rdata` one time unit after setting `addr` and `size`, on a falling edge. Register updates and the start and abort pulses both come from the rising edge that samples a write. The bench holds each write across exactly one rising edge and checks the pulse outputs at the very next falling edge. It checks one cycle later that the pulse has dropped. A completion strobe is given for one cycle, and its register effects are read back at the falling edge after that rising edge.

// File: rtl/bmide_pkg.sv
package bmide_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_BAD   = 2'd3
  } xfer_sz_e;

  // bit positions
  localparam int CMD_RUN = 0;
  localparam int CMD_DIR = 3;
  localparam int ST_BUSY = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_IRQ  = 2;

  // per-channel layout
  localparam int CH_STRIDE = 8;
  localparam int OFF_CMD   = 0;
  localparam int OFF_SPR0  = 1;
  localparam int OFF_STS   = 2;
  localparam int OFF_SPR1  = 3;
  localparam int OFF_PTR   = 4;

  localparam logic [7:0] STS_RESET = 8'h60;

  function automatic int sz_bytes(input logic [1:0] s);
    case (s)
      SZ_BYTE:  return 1;
      SZ_WORD:  return 2;
      SZ_DWORD: return 4;
      default:  return 0;
    endcase
  endfunction
endpackage

// File: rtl/bmide_chan.sv
module bmide_chan
  import bmide_pkg::*;
#(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cmd,
  input  logic          wr_sts,
  input  logic          wr_ptr,
  input  logic          spr0_we,
  input  logic          spr1_we,
  input  logic [7:0]    wbyte,
  input  logic [7:0]    spr0_d,
  input  logic [7:0]    spr1_d,
  input  logic [PW-1:0] wptr,
  input  logic          done,
  output logic [7:0]    cmd_q,
  output logic [7:0]    sts_q,
  output logic [7:0]    spr0_q,
  output logic [7:0]    spr1_q,
  output logic [PW-1:0] ptr_q,
  output logic          go_rise,
  output logic          go_fall
);
  logic [7:0]    cmd_n, sts_n, spr0_n, spr1_n;
  logic [PW-1:0] ptr_n;

  // run-bit edges caused by a command write; a completion suppresses them
  assign go_rise = wr_cmd && !done && !cmd_q[CMD_RUN] &&  wbyte[CMD_RUN];
  assign go_fall = wr_cmd && !done &&  cmd_q[CMD_RUN] && !wbyte[CMD_RUN];

  always_comb begin
    cmd_n  = cmd_q;
    sts_n  = sts_q;
    spr0_n = spr0_q;
    spr1_n = spr1_q;
    ptr_n  = ptr_q;

    if (wr_cmd) begin
      cmd_n = wbyte;
      if (cmd_q[CMD_RUN]) cmd_n[CMD_DIR] = cmd_q[CMD_DIR];
    end

    if (wr_sts) begin
      sts_n          = wbyte;
      sts_n[ST_BUSY] = sts_q[ST_BUSY];
      sts_n[ST_IRQ]  = sts_q[ST_IRQ] & ~wbyte[ST_IRQ];
      sts_n[ST_ERR]  = sts_q[ST_ERR] & ~wbyte[ST_ERR];
    end

    if (go_rise) sts_n[ST_BUSY] = 1'b1;
    if (go_fall) sts_n[ST_BUSY] = 1'b0;

    if (done) begin
      cmd_n[CMD_RUN] = 1'b0;
      sts_n[ST_BUSY] = 1'b0;
      sts_n[ST_IRQ]  = 1'b1;
    end

    if (wr_ptr) ptr_n = {wptr[PW-1:2], 2'b00};
    if (spr0_we) spr0_n = spr0_d;
    if (spr1_we) spr1_n = spr1_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      sts_q  <= STS_RESET;
      spr0_q <= '0;
      spr1_q <= '0;
      ptr_q  <= '0;
    end else begin
      cmd_q  <= cmd_n;
      sts_q  <= sts_n;
      spr0_q <= spr0_n;
      spr1_q <= spr1_n;
      ptr_q  <= ptr_n;
    end
  end

  assert_dir_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q[CMD_RUN] |=> (cmd_q[CMD_DIR] == $past(cmd_q[CMD_DIR])));

  assert_busy_on_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    go_rise |=> (sts_q[ST_BUSY] && cmd_q[CMD_RUN]));

  assert_busy_off_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    go_fall |=> !sts_q[ST_BUSY]);

  assert_irq_needs_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[ST_IRQ]) |-> $past(done));

  assert_ptr_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr |=> (ptr_q[1:0] == 2'b00));

  assert_done_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!cmd_q[CMD_RUN] && !sts_q[ST_BUSY] && sts_q[ST_IRQ]));
endmodule

// File: rtl/bmide_rdmux.sv
module bmide_rdmux
  import bmide_pkg::*;
#(
  parameter int NB = 16,
  parameter int DW = 32,
  localparam int AW = $clog2(NB),
  localparam int LANES = DW / 8
) (
  input  logic [NB*8-1:0] win,
  input  logic [AW-1:0]   addr,
  input  logic [1:0]      size,
  output logic [DW-1:0]   rdata
);
  always_comb begin
    rdata = '0;
    for (int k = 0; k < LANES; k++) begin
      if (k < sz_bytes(size) && (int'(addr) + k) < NB)
        rdata[8*k +: 8] = win[8*(int'(addr) + k) +: 8];
    end
  end
endmodule

// File: rtl/bmide_regs.sv
module bmide_regs
  import bmide_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DW     = 32,
  localparam int NB    = NUM_CH * CH_STRIDE,
  localparam int AW    = $clog2(NB),
  localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int DRW   = CHW + 1,
  localparam int LANES = DW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [1:0]        size,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [NUM_CH-1:0] drv_sel,
  input  logic [NUM_CH-1:0] dma_done,
  output logic              dma_start,
  output logic              dma_abort,
  output logic [DRW-1:0]    dma_drive,
  output logic [DW-1:0]     dma_ptr
);
  logic [NUM_CH-1:0] wr_cmd, wr_sts, wr_ptr, spr0_we, spr1_we;
  logic [NUM_CH-1:0] go_rise, go_fall;
  logic [7:0]        spr0_d [NUM_CH];
  logic [7:0]        spr1_d [NUM_CH];
  logic [7:0]        cmd_q  [NUM_CH];
  logic [7:0]        sts_q  [NUM_CH];
  logic [7:0]        spr0_q [NUM_CH];
  logic [7:0]        spr1_q [NUM_CH];
  logic [DW-1:0]     ptr_q  [NUM_CH];
  logic [NB*8-1:0]   win;
  logic              start_is_spare;

  assign start_is_spare = (int'(addr) % CH_STRIDE == OFF_SPR0) ||
                          (int'(addr) % CH_STRIDE == OFF_SPR1);

  // spare-byte lanes for plain writes that start on a spare offset
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      spr0_we[c] = 1'b0;
      spr1_we[c] = 1'b0;
      spr0_d[c]  = '0;
      spr1_d[c]  = '0;
      for (int k = 0; k < LANES; k++) begin
        if (wr_en && start_is_spare && k < sz_bytes(size)) begin
          if (int'(addr) + k == c*CH_STRIDE + OFF_SPR0) begin
            spr0_we[c] = 1'b1;
            spr0_d[c]  = wdata[8*k +: 8];
          end
          if (int'(addr) + k == c*CH_STRIDE + OFF_SPR1) begin
            spr1_we[c] = 1'b1;
            spr1_d[c]  = wdata[8*k +: 8];
          end
        end
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign wr_cmd[c] = wr_en && size == SZ_BYTE  && int'(addr) == c*CH_STRIDE + OFF_CMD;
    assign wr_sts[c] = wr_en && size == SZ_BYTE  && int'(addr) == c*CH_STRIDE + OFF_STS;
    assign wr_ptr[c] = wr_en && size == SZ_DWORD && int'(addr) == c*CH_STRIDE + OFF_PTR;

    bmide_chan #(.PW(DW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_cmd  (wr_cmd[c]),
      .wr_sts  (wr_sts[c]),
      .wr_ptr  (wr_ptr[c]),
      .spr0_we (spr0_we[c]),
      .spr1_we (spr1_we[c]),
      .wbyte   (wdata[7:0]),
      .spr0_d  (spr0_d[c]),
      .spr1_d  (spr1_d[c]),
      .wptr    (wdata),
      .done    (dma_done[c]),
      .cmd_q   (cmd_q[c]),
      .sts_q   (sts_q[c]),
      .spr0_q  (spr0_q[c]),
      .spr1_q  (spr1_q[c]),
      .ptr_q   (ptr_q[c]),
      .go_rise (go_rise[c]),
      .go_fall (go_fall[c])
    );

    assign win[c*CH_STRIDE*8 +: CH_STRIDE*8] =
      {ptr_q[c], spr1_q[c], sts_q[c], spr0_q[c], cmd_q[c]};
  end

  bmide_rdmux #(.NB(NB), .DW(DW)) u_rd (
    .win   (win),
    .addr  (addr),
    .size  (size),
    .rdata (rdata)
  );

  // request pulse register
  logic           start_n, abort_n;
  logic [DRW-1:0] drive_n;
  logic [DW-1:0]  ptr_n;

  always_comb begin
    start_n = 1'b0;
    abort_n = 1'b0;
    drive_n = '0;
    ptr_n   = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (go_rise[c]) begin
        start_n = 1'b1;
        ptr_n   = ptr_q[c];
        drive_n = {CHW'(c), drv_sel[c]};
      end
      if (go_fall[c]) begin
        abort_n = 1'b1;
        drive_n = {CHW'(c), drv_sel[c]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_start <= 1'b0;
      dma_abort <= 1'b0;
      dma_drive <= '0;
      dma_ptr   <= '0;
    end else begin
      dma_start <= start_n;
      dma_abort <= abort_n;
      dma_drive <= drive_n;
      dma_ptr   <= ptr_n;
    end
  end

  assert_req_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_start && dma_abort));

  assert_start_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |=> !dma_start);

  assert_start_ptr_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> (dma_ptr[1:0] == 2'b00));

  assert_one_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_rise, go_fall}));
endmodule

// File: tb/sim_bmide_regs.sv
module sim_bmide_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  drv_sel = '0;
  logic [1:0]  dma_done = '0;
  logic        dma_start, dma_abort;
  logic [1:0]  dma_drive;
  logic [31:0] dma_ptr;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  bmide_regs u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .size(size),
    .wdata(wdata), .rdata(rdata), .drv_sel(drv_sel), .dma_done(dma_done),
    .dma_start(dma_start), .dma_abort(dma_abort), .dma_drive(dma_drive),
    .dma_ptr(dma_ptr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one write held across one rising edge; returns at the following falling edge
  task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; size = s; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [1:0] s, output logic [31:0] d);
    addr = a; size = s;
    #1;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'd0, 2'd2, v);  chk("R1 ch0 low dword", v, 32'h0060_0000);
    rd(4'd8, 2'd2, v);  chk("R1 ch1 low dword", v, 32'h0060_0000);
    rd(4'd4, 2'd2, v);  chk("R1 ptr0", v, 32'h0);
    rd(4'd12, 2'd2, v); chk("R1 ptr1", v, 32'h0);
    chk("R1 pulses", {30'd0, dma_start, dma_abort}, 32'h0);
  endtask

  task automatic t_ptr();
    logic [31:0] v;
    wr(4'd4, 2'd2, 32'h1234_5677);
    rd(4'd4, 2'd2, v); chk("R8 ptr0 aligned", v, 32'h1234_5674);
    wr(4'd4, 2'd1, 32'h0000_FFFF);
    rd(4'd4, 2'd2, v); chk("R8 word write ignored", v, 32'h1234_5674);
    wr(4'd12, 2'd2, 32'hABCD_EF03);
    rd(4'd12, 2'd2, v); chk("R8 ptr1 aligned", v, 32'hABCD_EF00);
  endtask

  task automatic t_cmd_size();
    logic [31:0] v;
    wr(4'd0, 2'd1, 32'h0000_0009);
    chk("R2 no pulse on word write", {31'd0, dma_start}, 32'h0);
    rd(4'd0, 2'd0, v); chk("R2 cmd unchanged", v, 32'h0);
  endtask

  task automatic t_start();
    logic [31:0] v;
    drv_sel = 2'b10;
    wr(4'd0, 2'd0, 32'h09);
    chk("R4 start pulse", {31'd0, dma_start}, 32'h1);
    chk("R4 start ptr", dma_ptr, 32'h1234_5674);
    chk("R4 start drive", {30'd0, dma_drive}, 32'd0);
    rd(4'd0, 2'd0, v); chk("R4 cmd", v, 32'h09);
    rd(4'd2, 2'd0, v); chk("R4 busy set", v, 32'h61);
    @(negedge clk);
    chk("R4 pulse one cycle", {31'd0, dma_start}, 32'h0);
  endtask

  task automatic t_dirlock();
    logic [31:0] v;
    wr(4'd0, 2'd0, 32'h01);
    rd(4'd0, 2'd0, v); chk("R3 dir locked", v, 32'h09);
    chk("R3 no pulse", {30'd0, dma_start, dma_abort}, 32'h0);
  endtask

  task automatic t_status();
    logic [31:0] v;
    wr(4'd2, 2'd0, 32'h00);
    rd(4'd2, 2'd0, v); chk("R6 busy read-only", v, 32'h01);
    wr(4'd2, 2'd0, 32'h60);
    rd(4'd2, 2'd0, v); chk("R6 upper bits written", v, 32'h61);
    wr(4'd2, 2'd1, 32'h0000);
    rd(4'd2, 2'd0, v); chk("R6 word write ignored", v, 32'h61);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    drv_sel = 2'b11;
    wr(4'd0, 2'd0, 32'h08);
    chk("R5 abort pulse", {30'd0, dma_start, dma_abort}, 32'h1);
    chk("R5 abort drive", {30'd0, dma_drive}, 32'd1);
    rd(4'd2, 2'd0, v); chk("R5 busy cleared", v, 32'h60);
    rd(4'd0, 2'd0, v); chk("R5 cmd", v, 32'h08);
  endtask

  task automatic t_done();
    logic [31:0] v;
    wr(4'd8, 2'd0, 32'h01);
    chk("R4 ch1 start", {31'd0, dma_start}, 32'h1);
    chk("R4 ch1 ptr", dma_ptr, 32'hABCD_EF00);
    chk("R4 ch1 drive", {30'd0, dma_drive}, 32'd3);
    dma_done = 2'b10;
    @(posedge clk);
    @(negedge clk);
    dma_done = 2'b00;
    rd(4'd8, 2'd0, v);  chk("R9 run cleared", v, 32'h00);
    rd(4'd10, 2'd0, v); chk("R9 busy off irq on", v, 32'h64);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(4'd10, 2'd0, 32'h60);
    rd(4'd10, 2'd0, v); chk("R7 write 0 keeps irq", v, 32'h64);
    wr(4'd10, 2'd0, 32'h64);
    rd(4'd10, 2'd0, v); chk("R7 write 1 clears irq", v, 32'h60);
    wr(4'd10, 2'd0, 32'h66);
    rd(4'd10, 2'd0, v); chk("R7 write 1 never sets", v, 32'h60);
  endtask

  task automatic t_done_prio();
    logic [31:0] v;
    @(negedge clk);
    wr_en = 1'b1; addr = 4'd0; size = 2'd0; wdata = 32'h01; dma_done = 2'b01;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; dma_done = 2'b00;
    chk("R9 no start on done", {31'd0, dma_start}, 32'h0);
    rd(4'd0, 2'd0, v); chk("R9 done beats write", v, 32'h00);
    rd(4'd2, 2'd0, v); chk("R9 irq set ch0", v, 32'h64);
  endtask

  task automatic t_spare();
    logic [31:0] v;
    wr(4'd1, 2'd0, 32'hA5);
    rd(4'd1, 2'd0, v); chk("R10 spare byte", v, 32'hA5);
    wr(4'd1, 2'd2, 32'h4433_2211);
    rd(4'd0, 2'd2, v); chk("R10 dword over spares", v, 32'h3364_1100);
    rd(4'd4, 2'd2, v); chk("R10 ptr untouched", v, 32'h1234_5674);
  endtask

  task automatic t_read();
    logic [31:0] v;
    rd(4'd15, 2'd1, v); chk("R11 past window", v, 32'h0000_00AB);
    rd(4'd13, 2'd1, v); chk("R11 word read", v, 32'h0000_CDEF);
    rd(4'd0, 2'd3, v);  chk("R11 bad size", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ptr();
    t_cmd_size();
    t_start();
    t_dirlock();
    t_status();
    t_stop();
    t_done();
    t_w1c();
    t_done_prio();
    t_spare();
    t_read();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule